// File: doc/BRIEF.md
# Firmware Record Stream Loader

This block copies a firmware image into a target memory and then starts the target. The image arrives as a byte stream with a valid/ready handshake, and the total image length is given when the load starts. The image is a run of records. Each record names where its payload goes, gives how many payload bytes follow, and then carries those bytes. Every payload byte goes out through a byte-write port that names a 32-bit word and one of its four byte lanes.

When the records fill the image exactly, the loader starts the target. It turns on the target's interrupts, takes it out of reset and permits standby, all in one cycle. It then waits a bounded number of cycles for the target to report that initialisation is done. The loader ends in one of three states: success, a format error (a truncated header or a payload that runs past the image end) or a timeout error. It stays there until the next start.

Top module: `fw_record_loader`

## Requirements
- R1: After reset, `core_reset` is 1 and `irq_enable`, `allow_standby`, `busy`, `done_ok`, `err_format`, `err_timeout`, `in_ready` and `mem_we` are all 0.
- R2: A record is 4 bytes of destination address, least significant byte first, then 2 bytes of payload count, least significant byte first, then the payload. The payload byte at offset k goes to address A = dest + k, computed modulo 2^32. The write presents `mem_word` = A[31:2] and `mem_lane` = A[1:0].
- R3: `mem_we` is high in exactly the cycles in which a payload byte is accepted (`in_valid` and `in_ready` both high), and `mem_wdata` carries that byte. Header bytes and zero-length records cause no write.
- R4: If 1 to 5 image bytes remain when a record header is due, the loader raises `err_format` without accepting any of them.
- R5: If a record's count exceeds the bytes left after its header, `err_format` rises once the header has been taken, and no byte of that record is written. A count that exactly fills the image is legal.
- R6: When the image is consumed exactly (an image length of 0 included), `irq_enable` rises, `core_reset` falls and `allow_standby` rises, all in the same cycle.
- R7: If `init_done` is seen while the loader waits, `done_ok` rises and `busy` falls. At most one of `done_ok`, `err_format` and `err_timeout` is ever high.
- R8: If `init_done` does not arrive within `TIMEOUT_CYC` cycles of the bring-up cycle, `err_timeout` rises.
- R9: After an error, `in_ready` and `mem_we` stay low and the error output holds until the next start. A start clears all result outputs and drives `core_reset` back to 1.
- R10: `start` and `image_len` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load; honoured only when not busy |
| image_len | input | LEN_W | Total image size in bytes, sampled at start |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte present |
| in_ready | output | 1 | Loader takes the byte this cycle |
| mem_we | output | 1 | Byte write strobe |
| mem_word | output | 30 | Word address of the write |
| mem_lane | output | 2 | Byte lane within the word |
| mem_wdata | output | 8 | Byte to write |
| irq_enable | output | 1 | Target interrupts enabled |
| core_reset | output | 1 | Target held in reset |
| allow_standby | output | 1 | Target may enter standby |
| init_done | input | 1 | Target reports initialisation complete |
| busy | output | 1 | Load or wait in progress |
| done_ok | output | 1 | Load and bring-up succeeded |
| err_format | output | 1 | Image malformed |
| err_timeout | output | 1 | Init-done never came |

## Verification
The bench builds the loader with `LEN_W` = 12 and `TIMEOUT_CYC` = 40. The 40-cycle timeout lets the wait expire within a short run, and the bench checks the expiry cycle against a window a few cycles wide. The 12-bit length is still wide enough to show that a 16-bit record count is compared correctly against a smaller remaining image. The main image places one record at the top of the address space, so its addresses wrap past zero. It also includes a record that starts at lane 3, and it inserts bubbles into the stream.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

    localparam int HDR_BYTES = 6;
    localparam int CNT_W     = 16;
    localparam int DST_W     = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK,
        ST_HDR,
        ST_DATA,
        ST_BRING,
        ST_WAIT,
        ST_OK,
        ST_FAIL
    } ld_state_t;

    typedef enum logic [1:0] {
        FAIL_NONE,
        FAIL_FORMAT,
        FAIL_TIMEOUT
    } fail_t;

    typedef struct packed {
        logic             we;
        logic [DST_W-3:0] word;
        logic [1:0]       lane;
        logic [7:0]       data;
    } mem_wr_t;

    function automatic logic [DST_W-3:0] word_of(input logic [DST_W-1:0] a);
        return a[DST_W-1:2];
    endfunction

    function automatic logic [1:0] lane_of(input logic [DST_W-1:0] a);
        return a[1:0];
    endfunction

endpackage

// File: rtl/fwl_len_track.sv
module fwl_len_track #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] total,
    input  logic             dec,
    output logic [LEN_W-1:0] rem,
    output logic             is_zero,
    output logic             lt_hdr
);
    import fwl_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)       rem <= '0;
        else if (load) rem <= total;
        else if (dec)  rem <= rem - 1'b1;
    end

    assign is_zero = (rem == '0);
    assign lt_hdr  = (32'(rem) < HDR_BYTES);

endmodule

// File: rtl/fwl_hdr_collect.sv
module fwl_hdr_collect (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic                        take,
    input  logic [7:0]                  byte_in,
    output logic                        hdr_done,
    output logic [fwl_pkg::DST_W-1:0]   dest,
    output logic [fwl_pkg::CNT_W-1:0]   count
);
    import fwl_pkg::*;

    localparam int IDX_W = $clog2(HDR_BYTES);
    localparam int KEEP  = HDR_BYTES - 1;

    logic [IDX_W-1:0] idx;
    logic [7:0]       hb [KEEP];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (take) begin
            idx <= (idx == IDX_W'(HDR_BYTES - 1)) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < KEEP; i++) hb[i] <= '0;
        end else begin
            for (int i = 0; i < KEEP; i++)
                if (take && idx == IDX_W'(i)) hb[i] <= byte_in;
        end
    end

    assign hdr_done = take && (idx == IDX_W'(HDR_BYTES - 1));
    assign dest     = {hb[3], hb[2], hb[1], hb[0]};
    assign count    = {byte_in, hb[4]};

endmodule

// File: rtl/fwl_byte_writer.sv
module fwl_byte_writer (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [fwl_pkg::DST_W-1:0] dest_in,
    input  logic [fwl_pkg::CNT_W-1:0] cnt_in,
    input  logic                      wr,
    input  logic [7:0]                data,
    output fwl_pkg::mem_wr_t          port,
    output logic                      last
);
    import fwl_pkg::*;

    logic [DST_W-1:0] cur;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            cnt <= '0;
        end else if (load) begin
            cur <= dest_in;
            cnt <= cnt_in;
        end else if (wr) begin
            cur <= cur + 1'b1;
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        port.we   = wr;
        port.word = word_of(cur);
        port.lane = lane_of(cur);
        port.data = data;
    end

    assign last = (cnt == CNT_W'(1));

    // R3
    write_has_budget_chk: assert property (@(posedge clk) disable iff (rst)
        wr |-> (cnt != '0));

endmodule

// File: rtl/fwl_bringup.sv
module fwl_bringup #(
    parameter int TIMEOUT_CYC = 1_250_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic go,
    input  logic init_done,
    output logic irq_en,
    output logic core_rst,
    output logic standby_ok,
    output logic seen,
    output logic timed_out
);
    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

    logic [TMR_W-1:0] timer;
    logic             waiting;

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            irq_en     <= 1'b0;
            core_rst   <= 1'b1;
            standby_ok <= 1'b0;
            seen       <= 1'b0;
            timed_out  <= 1'b0;
            waiting    <= 1'b0;
            timer      <= '0;
        end else if (go) begin
            irq_en     <= 1'b1;
            core_rst   <= 1'b0;
            standby_ok <= 1'b1;
            waiting    <= 1'b1;
            timer      <= '0;
        end else if (waiting) begin
            if (init_done) begin
                seen    <= 1'b1;
                waiting <= 1'b0;
            end else if (timer == TMR_W'(TIMEOUT_CYC - 1)) begin
                timed_out <= 1'b1;
                waiting   <= 1'b0;
            end else begin
                timer <= timer + 1'b1;
            end
        end
    end

    // R6
    bringup_together_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_en) |-> (!core_rst && standby_ok));

    // R8
    timeout_without_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timed_out) |-> !$past(init_done));

endmodule

// File: rtl/fw_record_loader.sv
module fw_record_loader #(
    parameter int LEN_W       = 16,
    parameter int TIMEOUT_CYC = 1_250_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] image_len,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             mem_we,
    output logic [29:0]      mem_word,
    output logic [1:0]       mem_lane,
    output logic [7:0]       mem_wdata,
    output logic             irq_enable,
    output logic             core_reset,
    output logic             allow_standby,
    input  logic             init_done,
    output logic             busy,
    output logic             done_ok,
    output logic             err_format,
    output logic             err_timeout
);
    import fwl_pkg::*;

    localparam int CMP_W = (LEN_W > CNT_W) ? LEN_W : CNT_W;

    ld_state_t        state;
    fail_t            fail;
    logic             accept, start_ok, hdr_take, wr_load, wr_go, go;
    logic [LEN_W-1:0] rem;
    logic             rem_zero, rem_short;
    logic             hdr_done, too_long, rec_empty, last_byte;
    logic [DST_W-1:0] hdr_dest;
    logic [CNT_W-1:0] hdr_cnt;
    logic [CMP_W-1:0] rem_after;
    logic             seen, timed_out;
    mem_wr_t          wport;

    assign in_ready  = (state == ST_HDR) || (state == ST_DATA);
    assign accept    = in_valid && in_ready;
    assign start_ok  = start && (state == ST_IDLE || state == ST_OK || state == ST_FAIL);
    assign hdr_take  = accept && (state == ST_HDR);
    assign wr_go     = accept && (state == ST_DATA);
    assign rem_after = CMP_W'(rem) - 1'b1;
    assign too_long  = CMP_W'(hdr_cnt) > rem_after;
    assign rec_empty = (hdr_cnt == '0);
    assign wr_load   = hdr_done && !too_long && !rec_empty;
    assign go        = (state == ST_BRING);

    fwl_len_track #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst(rst), .load(start_ok), .total(image_len), .dec(accept),
        .rem(rem), .is_zero(rem_zero), .lt_hdr(rem_short)
    );

    fwl_hdr_collect u_hdr (
        .clk(clk), .rst(rst), .clear(start_ok), .take(hdr_take), .byte_in(in_data),
        .hdr_done(hdr_done), .dest(hdr_dest), .count(hdr_cnt)
    );

    fwl_byte_writer u_wr (
        .clk(clk), .rst(rst), .load(wr_load), .dest_in(hdr_dest), .cnt_in(hdr_cnt),
        .wr(wr_go), .data(in_data), .port(wport), .last(last_byte)
    );

    fwl_bringup #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_bring (
        .clk(clk), .rst(rst), .arm(start_ok), .go(go), .init_done(init_done),
        .irq_en(irq_enable), .core_rst(core_reset), .standby_ok(allow_standby),
        .seen(seen), .timed_out(timed_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            fail  <= FAIL_NONE;
        end else if (start_ok) begin
            state <= ST_CHK;
            fail  <= FAIL_NONE;
        end else begin
            case (state)
                ST_CHK: begin
                    if (rem_zero) begin
                        state <= ST_BRING;
                    end else if (rem_short) begin
                        state <= ST_FAIL;
                        fail  <= FAIL_FORMAT;
                    end else begin
                        state <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (hdr_done) begin
                        if (too_long) begin
                            state <= ST_FAIL;
                            fail  <= FAIL_FORMAT;
                        end else if (rec_empty) begin
                            state <= ST_CHK;
                        end else begin
                            state <= ST_DATA;
                        end
                    end
                end
                ST_DATA:  if (wr_go && last_byte) state <= ST_CHK;
                ST_BRING: state <= ST_WAIT;
                ST_WAIT: begin
                    if (seen) begin
                        state <= ST_OK;
                    end else if (timed_out) begin
                        state <= ST_FAIL;
                        fail  <= FAIL_TIMEOUT;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    assign mem_we      = wport.we;
    assign mem_word    = wport.word;
    assign mem_lane    = wport.lane;
    assign mem_wdata   = wport.data;
    assign busy        = !(state == ST_IDLE || state == ST_OK || state == ST_FAIL);
    assign done_ok     = (state == ST_OK);
    assign err_format  = (fail == FAIL_FORMAT);
    assign err_timeout = (fail == FAIL_TIMEOUT);

    // R7
    single_result_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_ok, err_format, err_timeout}));

    // R9
    quiet_after_error_chk: assert property (@(posedge clk) disable iff (rst)
        (err_format || err_timeout) |-> (!mem_we && !in_ready));

    // R4
    format_error_from_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_format) |-> $past(busy));

endmodule

// File: tb/fw_record_loader_test.sv
module fw_record_loader_test;
    localparam int LEN_W = 12;
    localparam int TO    = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [LEN_W-1:0] image_len = '0;
    logic [7:0] in_data = '0;
    logic in_valid = 1'b0;
    logic init_done = 1'b0;
    logic in_ready, mem_we, irq_enable, core_reset, allow_standby;
    logic busy, done_ok, err_format, err_timeout;
    logic [29:0] mem_word;
    logic [1:0]  mem_lane;
    logic [7:0]  mem_wdata;

    always #2 clk = ~clk;

    fw_record_loader #(.LEN_W(LEN_W), .TIMEOUT_CYC(TO)) uut (
        .clk(clk), .rst(rst), .start(start), .image_len(image_len),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .mem_we(mem_we), .mem_word(mem_word), .mem_lane(mem_lane), .mem_wdata(mem_wdata),
        .irq_enable(irq_enable), .core_reset(core_reset), .allow_standby(allow_standby),
        .init_done(init_done), .busy(busy), .done_ok(done_ok),
        .err_format(err_format), .err_timeout(err_timeout)
    );

    // Stimulus table: record destination, count, and expected first write word/lane
    localparam int NREC = 4;
    localparam logic [31:0] T_ADDR [NREC] = '{32'h0000_1000, 32'h0000_2003, 32'h0000_0040, 32'hFFFF_FFFE};
    localparam logic [15:0] T_LEN  [NREC] = '{16'd5, 16'd3, 16'd0, 16'd3};
    localparam logic [29:0] T_WORD [NREC] = '{30'h400, 30'h800, 30'h10, 30'h3FFF_FFFF};
    localparam logic [1:0]  T_LANE [NREC] = '{2'd0, 2'd3, 2'd0, 2'd2};

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [7:0]  img [64];
    int          img_n;
    logic [29:0] exp_word [64];
    logic [1:0]  exp_lane [64];
    logic [7:0]  exp_data [64];
    int          exp_n;
    logic [29:0] act_word [64];
    logic [1:0]  act_lane [64];
    int          wr_idx;
    int          first_idx [NREC];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (wr_idx < exp_n) begin
                chk("R2 write word", 64'(mem_word), 64'(exp_word[wr_idx]));
                chk("R2 write lane", 64'(mem_lane), 64'(exp_lane[wr_idx]));
                chk("R3 write data", 64'(mem_wdata), 64'(exp_data[wr_idx]));
            end else begin
                chk("R3 unexpected write", 64'(wr_idx), 64'(exp_n));
            end
            if (wr_idx < 64) begin
                act_word[wr_idx] = mem_word;
                act_lane[wr_idx] = mem_lane;
            end
            wr_idx++;
        end
    end

    task automatic clear_model();
        img_n = 0; exp_n = 0; wr_idx = 0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        img[img_n] = b;
        img_n++;
    endtask

    task automatic push_rec(input logic [31:0] addr, input logic [15:0] len, input bit gen_exp);
        push_byte(addr[7:0]);  push_byte(addr[15:8]);
        push_byte(addr[23:16]); push_byte(addr[31:24]);
        push_byte(len[7:0]);   push_byte(len[15:8]);
        for (int k = 0; k < int'(len); k++) begin
            logic [7:0]  d;
            logic [31:0] a;
            d = 8'((img_n * 13 + 5) & 8'hFF);
            a = addr + 32'(k);
            push_byte(d);
            if (gen_exp) begin
                exp_word[exp_n] = a[31:2];
                exp_lane[exp_n] = a[1:0];
                exp_data[exp_n] = d;
                exp_n++;
            end
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start_run(input int len);
        @(posedge clk); #1;
        image_len = LEN_W'(len);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit gap);
        if (gap) begin
            in_valid = 1'b0;
            cyc(1);
        end
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) cyc(1);
        cyc(1);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
    end

    initial begin
        clear_model();
        cyc(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 core_reset", 64'(core_reset), 64'd1);
        chk("R1 irq_enable", 64'(irq_enable), 64'd0);
        chk("R1 allow_standby", 64'(allow_standby), 64'd0);
        chk("R1 busy/done/err", 64'({busy, done_ok, err_format, err_timeout}), 64'd0);
        chk("R1 in_ready/mem_we", 64'({in_ready, mem_we}), 64'd0);

        // Main table walk: R2 R3 R6 R7 R10
        clear_model();
        for (int r = 0; r < NREC; r++) begin
            first_idx[r] = exp_n;
            push_rec(T_ADDR[r], T_LEN[r], 1'b1);
        end
        start_run(img_n);
        for (int i = 0; i < img_n; i++) begin
            send(img[i], (i % 3) == 1);
            if (i == 10) begin
                start = 1'b1; image_len = LEN_W'(6);
                cyc(1);
                start = 1'b0; image_len = LEN_W'(img_n);
                chk("R10 busy held through ignored start", 64'(busy), 64'd1);
            end
        end
        cyc(4);
        @(negedge clk);
        chk("R6 irq_enable", 64'(irq_enable), 64'd1);
        chk("R6 core_reset", 64'(core_reset), 64'd0);
        chk("R6 allow_standby", 64'(allow_standby), 64'd1);
        chk("R7 not done before init", 64'(done_ok), 64'd0);
        cyc(3);
        init_done = 1'b1;
        cyc(2);
        init_done = 1'b0;
        cyc(2);
        @(negedge clk);
        chk("R7 done_ok", 64'(done_ok), 64'd1);
        chk("R7 busy low", 64'(busy), 64'd0);
        chk("R3 write count incl zero-length record", 64'(wr_idx), 64'd11);
        for (int r = 0; r < NREC; r++) begin
            if (T_LEN[r] != 0) begin
                chk("R2 table first word", 64'(act_word[first_idx[r]]), 64'(T_WORD[r]));
                chk("R2 table first lane", 64'(act_lane[first_idx[r]]), 64'(T_LANE[r]));
            end
        end

        // R4: image shorter than a header
        clear_model();
        start_run(4);
        chk("R9 start reasserts core_reset", 64'(core_reset), 64'd1);
        chk("R9 start clears done_ok", 64'(done_ok), 64'd0);
        in_valid = 1'b1; in_data = 8'h55;
        cyc(4);
        @(negedge clk);
        chk("R4 err_format short header", 64'(err_format), 64'd1);
        chk("R4 no byte taken", 64'(in_ready), 64'd0);
        in_valid = 1'b0;

        // R5: payload overruns image end
        clear_model();
        push_rec(32'h0000_0100, 16'd8, 1'b0);
        start_run(10);
        for (int i = 0; i < 6; i++) send(img[i], 1'b0);
        cyc(1);
        @(negedge clk);
        chk("R5 err_format overrun", 64'(err_format), 64'd1);
        in_valid = 1'b1; in_data = 8'hAA;
        cyc(4);
        @(negedge clk);
        chk("R9 in_ready low after error", 64'(in_ready), 64'd0);
        chk("R5 no writes on overrun", 64'(wr_idx), 64'd0);
        in_valid = 1'b0;

        // R4: trailing fragment after a good record
        clear_model();
        push_rec(32'h0000_0010, 16'd2, 1'b1);
        start_run(11);
        for (int i = 0; i < img_n; i++) send(img[i], 1'b0);
        cyc(3);
        @(negedge clk);
        chk("R4 err_format trailing fragment", 64'(err_format), 64'd1);
        chk("R3 writes before fragment", 64'(wr_idx), 64'd2);

        // R6 R7: empty image
        clear_model();
        start_run(0);
        chk("R9 start clears err_format", 64'(err_format), 64'd0);
        cyc(3);
        @(negedge clk);
        chk("R6 empty image bring-up", 64'({irq_enable, core_reset, allow_standby}), 64'b101);
        init_done = 1'b1;
        cyc(4);
        init_done = 1'b0;
        @(negedge clk);
        chk("R7 empty image done", 64'(done_ok), 64'd1);

        // R8: timeout
        clear_model();
        push_rec(32'h0000_0200, 16'd1, 1'b1);
        start_run(img_n);
        for (int i = 0; i < img_n; i++) send(img[i], 1'b0);
        for (int g = 0; g < 20 && !irq_enable; g++) @(negedge clk);
        chk("R6 bring-up before timeout", 64'(irq_enable), 64'd1);
        repeat (TO - 4) @(negedge clk);
        chk("R8 no timeout early", 64'(err_timeout), 64'd0);
        repeat (8) @(negedge clk);
        chk("R8 err_timeout", 64'(err_timeout), 64'd1);
        chk("R7 no done on timeout", 64'(done_ok), 64'd0);
        init_done = 1'b1;
        repeat (5) @(negedge clk);
        init_done = 1'b0;
        chk("R9 timeout held until start", 64'(err_timeout), 64'd1);
        chk("R3 single write in timeout run", 64'(wr_idx), 64'd1);

        // R9: recovery after an error
        clear_model();
        push_rec(32'h0000_0301, 16'd2, 1'b1);
        init_done = 1'b1;
        start_run(img_n);
        for (int i = 0; i < img_n; i++) send(img[i], 1'b0);
        cyc(6);
        init_done = 1'b0;
        @(negedge clk);
        chk("R9 recovered to done", 64'({done_ok, err_timeout, err_format}), 64'b100);
        chk("R9 recovered writes", 64'(wr_idx), 64'd2);

        summary();
    end
endmodule